// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial-peripheral slave front end of a paged flash memory that has two page buffers. It oversamples chip select, serial clock and serial data into the system clock domain. On every select falling edge it works out whether the host idles the clock low or high. It then shifts in an opcode and, where the opcode calls for one, a three-byte address and a number of trailing dummy bytes. Once the header is complete it hands the core a one-cycle command strobe that carries the opcode, a page field and a byte field. How the address splits into those fields depends on the opcode.

For read-type commands the block then streams bytes that the core supplies, most significant bit first, on falling clock edges. It pulses a request each time it takes a byte. The serial output is enabled only while a frame is open. The flash array, the buffer storage and the timing of program operations belong to the core. Bytes that follow a complete header are not parsed here.

Top module: `flash_cmd_frontend`

## Requirements
- R1: A frame opens only on a high-to-low transition of `spi_cs_n` and closes when it returns high. While deselected, clock and data activity produce no strobe. `spi_miso_oe` is 1 inside a frame and 0 outside one.
- R2: Header bits are captured on rising `spi_sck` edges, most significant bit first. Output bits change only on falling `spi_sck` edges.
- R3: `cmd_idle_high` takes the level of `spi_sck` seen at each select falling edge. It is 1 after reset.
- R4: Page-addressed opcodes (52h, 53h, 55h, 58h, 59h, 60h, 61h, 68h, 81h, 82h, 83h, 85h, 86h, 88h, 89h, D2h, E8h) report address bits [18:9] as the page and bits [8:0] as the byte. The top five address bits are ignored.
- R5: Buffer opcodes (84h, 87h, 54h, 56h, D4h, D6h) report page 0 and address bits [8:0] as the byte.
- R6: Opcode 50h reports page {address[18:12], 000b} and byte 0.
- R7: Opcodes 52h, 68h, D2h and E8h wait for 4 dummy bytes after the address. Opcodes 54h, 56h, D4h and D6h wait for 1 dummy byte. All other opcodes wait for none. The strobe follows the last header bit.
- R8: Opcodes 57h and D7h take no address. They strobe right after the opcode byte, with page 0 and byte 0.
- R9: Any other opcode gives no strobe, and the rest of its frame is ignored.
- R10: A frame whose select rises before its header is complete gives no strobe.
- R11: `cmd_valid` is high for exactly one system clock per accepted command.
- R12: After the strobe of a read-type opcode (57h, D7h, 52h, 68h, D2h, E8h, 54h, 56h, D4h, D6h), successive `tx_byte` values appear on `spi_miso` MSB first. `tx_next` pulses each time a byte is taken. Otherwise `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| tx_byte | input | 8 | Next byte to send, supplied by the core |
| tx_next | output | 1 | Pulse: `tx_byte` was taken |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Opcode of the command |
| cmd_page | output | PAGE_W | Page (or block-derived page) field |
| cmd_byte | output | BYTE_W | Byte-in-page field |
| cmd_idle_high | output | 1 | Clock idle level sampled at frame start |

## Verification
The bench builds the block with its default parameters: a 10-bit page, a 9-bit byte, three address bytes, dummy counts of 4 and 1, and a two-stage synchroniser. The serial clock runs at sixteen system clocks per bit. With these values every opcode class, both dummy lengths and the whole 24-bit address space are within reach of random frames in either clock idle level. Directed frames add header cut-offs at several depths, unknown opcodes, and clock activity while deselected.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_STATUS,
        CLS_PAGE,
        CLS_BUF,
        CLS_BLOCK
    } op_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } fe_state_e;

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);
    // STAGES must be at least 2
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i};
        end
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/flash_fe_decode.sv
module flash_fe_decode
    import flash_fe_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int DUMMY_LONG  = 4,
    parameter int DUMMY_SHORT = 1
) (
    input  logic [7:0]       opcode_i,
    output op_class_e        cls_o,
    output logic [CNT_W-1:0] dummy_o,
    output logic             rd_o
);
    always_comb begin
        cls_o   = CLS_BAD;
        dummy_o = '0;
        rd_o    = 1'b0;
        unique case (opcode_i)
            8'h57, 8'hD7: begin
                cls_o = CLS_STATUS;
                rd_o  = 1'b1;
            end
            8'h52, 8'h68, 8'hD2, 8'hE8: begin
                cls_o   = CLS_PAGE;
                dummy_o = CNT_W'(DUMMY_LONG);
                rd_o    = 1'b1;
            end
            8'h54, 8'h56, 8'hD4, 8'hD6: begin
                cls_o   = CLS_BUF;
                dummy_o = CNT_W'(DUMMY_SHORT);
                rd_o    = 1'b1;
            end
            8'h84, 8'h87: cls_o = CLS_BUF;
            8'h50:        cls_o = CLS_BLOCK;
            8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61, 8'h81, 8'h82,
            8'h83, 8'h85, 8'h86, 8'h88, 8'h89: cls_o = CLS_PAGE;
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_fe_tx.sv
module flash_fe_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_on_i,
    input  logic       arm_i,
    input  logic       sck_fall_i,
    input  logic [7:0] tx_byte_i,
    output logic       miso_o,
    output logic       tx_next_o
);
    typedef struct packed {
        logic       act;
        logic [7:0] sh;
        logic [2:0] cnt;
        logic       miso;
        logic       nxt;
    } tx_regs_t;

    tx_regs_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.nxt = 1'b0;
        if (!frame_on_i) begin
            t_d.act  = 1'b0;
            t_d.miso = 1'b0;
            t_d.cnt  = '0;
        end else if (arm_i) begin
            t_d.act = 1'b1;
            t_d.sh  = tx_byte_i;
            t_d.cnt = '0;
            t_d.nxt = 1'b1;
        end else if (t_q.act && sck_fall_i) begin
            t_d.miso = t_q.sh[7];
            t_d.sh   = {t_q.sh[6:0], 1'b0};
            t_d.cnt  = t_q.cnt + 3'd1;
            if (t_q.cnt == 3'd7) begin
                t_d.sh  = tx_byte_i;
                t_d.nxt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign miso_o    = t_q.miso;
    assign tx_next_o = t_q.nxt;

    // R12
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.act |-> (t_q.miso == 1'b0));

    // R12
    take_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.nxt |-> t_q.act);

    // R2
    change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on_i && $past(frame_on_i) && !$past(sck_fall_i)) |-> $stable(t_q.miso));
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import flash_fe_pkg::*;
#(
    parameter int PAGE_W      = 10,
    parameter int BYTE_W      = 9,
    parameter int ADDR_BYTES  = 3,
    parameter int BLOCK_W     = 7,
    parameter int DUMMY_LONG  = 4,
    parameter int DUMMY_SHORT = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [7:0]        tx_byte,
    output logic              tx_next,
    output logic              cmd_valid,
    output logic [7:0]        cmd_opcode,
    output logic [PAGE_W-1:0] cmd_page,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_idle_high
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int MAXC   = (DUMMY_LONG > ADDR_BYTES) ? DUMMY_LONG : ADDR_BYTES;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int PG_LSB = BYTE_W;
    localparam int BLK_HI = BYTE_W + PAGE_W - 1;

    typedef struct packed {
        fe_state_e         st;
        logic [2:0]        bitc;
        logic [CNT_W-1:0]  bytec;
        logic [CNT_W-1:0]  dum;
        logic [7:0]        sh;
        logic [7:0]        op;
        op_class_e         cls;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic              idle_hi;
        logic              cs_prev;
        logic              sck_prev;
        logic              vld;
        logic              arm;
        logic [PAGE_W-1:0] pg;
        logic [BYTE_W-1:0] by;
    } fe_regs_t;

    fe_regs_t r_d, r_q;

    logic [2:0]        sync_lvl;
    logic              cs_lvl, sck_lvl, mosi_lvl;
    logic              cs_fall, cs_rise, sck_rise, sck_fall;
    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] addr_in;
    op_class_e         dec_cls;
    logic [CNT_W-1:0]  dec_dummy;
    logic              dec_rd;
    logic              fire;

    // bit 0 chip select, bit 1 clock, bit 2 data
    flash_fe_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i({spi_mosi, spi_sck, spi_cs_n}),
        .lvl_o(sync_lvl)
    );

    assign cs_lvl   = sync_lvl[0];
    assign sck_lvl  = sync_lvl[1];
    assign mosi_lvl = sync_lvl[2];
    assign cs_fall  = r_q.cs_prev & ~cs_lvl;
    assign cs_rise  = ~r_q.cs_prev & cs_lvl;
    assign sck_rise = ~r_q.sck_prev & sck_lvl;
    assign sck_fall = r_q.sck_prev & ~sck_lvl;

    assign byte_in = {r_q.sh[6:0], mosi_lvl};
    assign addr_in = {r_q.addr[ADDR_W-9:0], byte_in};

    flash_fe_decode #(
        .CNT_W      (CNT_W),
        .DUMMY_LONG (DUMMY_LONG),
        .DUMMY_SHORT(DUMMY_SHORT)
    ) u_dec (
        .opcode_i(byte_in),
        .cls_o   (dec_cls),
        .dummy_o (dec_dummy),
        .rd_o    (dec_rd)
    );

    always_comb begin
        r_d          = r_q;
        r_d.vld      = 1'b0;
        r_d.arm      = 1'b0;
        r_d.cs_prev  = cs_lvl;
        r_d.sck_prev = sck_lvl;
        fire         = 1'b0;

        if (cs_fall) begin
            r_d.st      = ST_OPCODE;
            r_d.bitc    = '0;
            r_d.bytec   = '0;
            r_d.addr    = '0;
            r_d.idle_hi = sck_lvl;
        end else if (cs_lvl) begin
            r_d.st = ST_IDLE;
        end else if (sck_rise && (r_q.st == ST_OPCODE || r_q.st == ST_ADDR
                                  || r_q.st == ST_DUMMY)) begin
            r_d.sh   = byte_in;
            r_d.bitc = r_q.bitc + 3'd1;
            if (r_q.bitc == 3'd7) begin
                unique case (r_q.st)
                    ST_OPCODE: begin
                        r_d.op    = byte_in;
                        r_d.cls   = dec_cls;
                        r_d.rd    = dec_rd;
                        r_d.dum   = dec_dummy;
                        r_d.bytec = '0;
                        if (dec_cls == CLS_BAD)         r_d.st = ST_SKIP;
                        else if (dec_cls == CLS_STATUS) fire = 1'b1;
                        else                            r_d.st = ST_ADDR;
                    end
                    ST_ADDR: begin
                        r_d.addr = addr_in;
                        if (r_q.bytec == CNT_W'(ADDR_BYTES - 1)) begin
                            r_d.bytec = '0;
                            if (r_q.dum == '0) fire = 1'b1;
                            else               r_d.st = ST_DUMMY;
                        end else begin
                            r_d.bytec = r_q.bytec + CNT_W'(1);
                        end
                    end
                    ST_DUMMY: begin
                        if (r_q.bytec == r_q.dum - CNT_W'(1)) fire = 1'b1;
                        else r_d.bytec = r_q.bytec + CNT_W'(1);
                    end
                    default: ;
                endcase
            end
        end

        if (fire) begin
            r_d.st  = ST_DATA;
            r_d.vld = 1'b1;
            r_d.arm = r_d.rd;
            r_d.pg  = '0;
            r_d.by  = '0;
            unique case (r_d.cls)
                CLS_PAGE: begin
                    r_d.pg = r_d.addr[PG_LSB +: PAGE_W];
                    r_d.by = r_d.addr[BYTE_W-1:0];
                end
                CLS_BUF: r_d.by = r_d.addr[BYTE_W-1:0];
                CLS_BLOCK: r_d.pg = {r_d.addr[BLK_HI -: BLOCK_W],
                                     {(PAGE_W-BLOCK_W){1'b0}}};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.idle_hi  <= 1'b1;
            r_q.sck_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    flash_fe_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_on_i(r_q.st != ST_IDLE),
        .arm_i     (r_q.arm),
        .sck_fall_i(sck_fall),
        .tx_byte_i (tx_byte),
        .miso_o    (spi_miso),
        .tx_next_o (tx_next)
    );

    assign spi_miso_oe   = (r_q.st != ST_IDLE);
    assign cmd_valid     = r_q.vld;
    assign cmd_opcode    = r_q.op;
    assign cmd_page      = r_q.pg;
    assign cmd_byte      = r_q.by;
    assign cmd_idle_high = r_q.idle_hi;

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |=> !r_q.vld);

    // R1
    deselect_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !spi_miso_oe);

    // R3
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (r_q.idle_hi == $past(sck_lvl)));

    // R9
    bad_opcode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> !r_q.vld);

    // R8
    status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && r_q.cls == CLS_STATUS) |-> (r_q.pg == '0 && r_q.by == '0));
endmodule

// File: tb/tb_flash_cmd_frontend.sv
`timescale 1ns/100ps
module tb_flash_cmd_frontend;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe, tx_next, cmd_valid, cmd_idle_high;
    logic [7:0] tx_byte, cmd_opcode;
    logic [9:0] cmd_page;
    logic [8:0] cmd_byte;

    always #2.5 clk = ~clk;

    flash_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .tx_byte(tx_byte), .tx_next(tx_next), .cmd_valid(cmd_valid),
        .cmd_opcode(cmd_opcode), .cmd_page(cmd_page), .cmd_byte(cmd_byte),
        .cmd_idle_high(cmd_idle_high)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // core responder: byte index advances on each take
    int         resp_n = 0;
    logic [7:0] resp_base = 8'hA5;
    assign tx_byte = resp_base + 8'(resp_n);
    always @(posedge clk) if (tx_next) resp_n <= resp_n + 1;

    // strobe monitor
    int         n_strobe = 0;
    logic [7:0] cap_op;
    logic [9:0] cap_pg;
    logic [8:0] cap_by;
    always @(negedge clk) if (cmd_valid) begin
        n_strobe <= n_strobe + 1;
        cap_op   <= cmd_opcode;
        cap_pg   <= cmd_page;
        cap_by   <= cmd_byte;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // 0 bad, 1 status, 2 page, 3 buffer, 4 block
    function automatic int cls_of(input logic [7:0] op);
        case (op)
            8'h57, 8'hD7: return 1;
            8'h84, 8'h87, 8'h54, 8'h56, 8'hD4, 8'hD6: return 3;
            8'h50: return 4;
            8'h52, 8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61, 8'h68, 8'h81,
            8'h82, 8'h83, 8'h85, 8'h86, 8'h88, 8'h89, 8'hD2, 8'hE8: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int dummies(input logic [7:0] op);
        case (op)
            8'h52, 8'h68, 8'hD2, 8'hE8: return 4;
            8'h54, 8'h56, 8'hD4, 8'hD6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_read(input logic [7:0] op);
        return (cls_of(op) == 1) || (dummies(op) != 0);
    endfunction

    function automatic logic [9:0] exp_page(input logic [7:0] op, input logic [23:0] a);
        case (cls_of(op))
            2: return a[18:9];
            4: return {a[18:12], 3'b000};
            default: return 10'd0;
        endcase
    endfunction

    function automatic logic [8:0] exp_byte(input logic [7:0] op, input logic [23:0] a);
        if (cls_of(op) == 2 || cls_of(op) == 3) return a[8:0];
        return 9'd0;
    endfunction

    // cut < 0 means the whole header is sent
    task automatic frame(input bit idle_hi, input logic [7:0] op, input logic [23:0] a,
                         input int cut, input int n_data);
        int   c      = cls_of(op);
        int   hdr    = (c == 1) ? 1 : 4 + dummies(op);
        int   total  = (cut >= 0) ? cut : (hdr + n_data) * 8;
        bit   full   = (cut < 0);
        bit   rd     = is_read(op) && full;
        int   s0     = n_strobe;
        int   r0     = resp_n;
        logic [7:0] rx = 8'h00;
        logic [7:0] bytes [0:3];
        bytes[0] = op; bytes[1] = a[23:16]; bytes[2] = a[15:8]; bytes[3] = a[7:0];
        spi_sck = idle_hi;
        wclk(HALF);
        spi_cs_n = 1'b0;
        wclk(HALF);
        chk(spi_miso_oe == 1'b1, "R1", "oe in frame", 32'(spi_miso_oe), 1);
        for (int i = 0; i < total; i++) begin
            int bi = i / 8;
            spi_sck  = 1'b0;
            spi_mosi = (bi < 4 && (c != 1 || bi == 0)) ? bytes[bi][7 - (i % 8)]
                                                        : 1'($urandom_range(0, 1));
            wclk(HALF);
            if (rd && i >= hdr * 8) begin
                rx = {rx[6:0], spi_miso};
                if (i % 8 == 7) begin
                    logic [7:0] e = resp_base + 8'(r0 + (i / 8 - hdr));
                    chk(rx == e, "R12", "read byte", 32'(rx), 32'(e));
                end
            end else if (i >= hdr * 8 && full) begin
                chk(spi_miso == 1'b0, "R12", "miso quiet", 32'(spi_miso), 0);
            end
            spi_sck = 1'b1;
            wclk(HALF);
        end
        if (!idle_hi) spi_sck = 1'b0;
        wclk(HALF);
        spi_cs_n = 1'b1;
        wclk(10);
        chk(spi_miso_oe == 1'b0, "R1", "oe after frame", 32'(spi_miso_oe), 0);
        chk(cmd_idle_high == idle_hi, "R3", "idle level", 32'(cmd_idle_high), 32'(idle_hi));
        if (!full) begin
            chk(n_strobe == s0, "R10", "aborted strobes", 32'(n_strobe - s0), 0);
        end else if (c == 0) begin
            chk(n_strobe == s0, "R9", "bad-op strobes", 32'(n_strobe - s0), 0);
        end else begin
            chk(n_strobe == s0 + 1, "R11", "strobe count", 32'(n_strobe - s0), 1);
            chk(cap_op == op, "R2", "opcode", 32'(cap_op), 32'(op));
            chk(cap_pg == exp_page(op, a), (c == 4) ? "R6" : (c == 3) ? "R5" : (c == 1) ? "R8" : "R4",
                "page", 32'(cap_pg), 32'(exp_page(op, a)));
            chk(cap_by == exp_byte(op, a), (c == 3) ? "R5" : (c == 2) ? "R4" : "R8",
                "byte", 32'(cap_by), 32'(exp_byte(op, a)));
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    logic [7:0] ops [0:25] = '{8'h52, 8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61,
        8'h68, 8'h81, 8'h82, 8'h83, 8'h85, 8'h86, 8'h88, 8'h89, 8'hD2, 8'hE8,
        8'h84, 8'h87, 8'h54, 8'h56, 8'hD4, 8'hD6, 8'h50, 8'h57, 8'hD7};

    initial begin
        void'($urandom(32'd20240607));
        wclk(6);
        rst_n = 1'b1;
        wclk(6);
        // R3 reset state
        chk(cmd_idle_high == 1'b1, "R3", "reset idle level", 32'(cmd_idle_high), 1);
        chk(cmd_valid == 1'b0, "R11", "reset strobe", 32'(cmd_valid), 0);
        chk(spi_miso_oe == 1'b0, "R1", "reset oe", 32'(spi_miso_oe), 0);
        chk(spi_miso == 1'b0, "R12", "reset miso", 32'(spi_miso), 0);

        // R1: activity while deselected is ignored
        begin
            int s0 = n_strobe;
            for (int i = 0; i < 40; i++) begin
                spi_sck = ~spi_sck; spi_mosi = 1'($urandom_range(0, 1));
                wclk(HALF);
            end
            spi_sck = 1'b1;
            wclk(HALF);
            chk(n_strobe == s0, "R1", "deselected strobes", 32'(n_strobe - s0), 0);
            chk(spi_miso_oe == 1'b0, "R1", "deselected oe", 32'(spi_miso_oe), 0);
        end

        // directed corners
        frame(1'b0, 8'h53, 24'hFFFFFF, -1, 0);  // R4 reserved bits ignored
        frame(1'b1, 8'h82, 24'h03_FE_01, -1, 0); // R4
        frame(1'b1, 8'h84, 24'hFF_FF_FF, -1, 0); // R5
        frame(1'b0, 8'h54, 24'h12_34_56, -1, 2); // R5 R7 one dummy
        frame(1'b1, 8'h50, 24'h07_F5_55, -1, 0); // R6
        frame(1'b0, 8'hE8, 24'h01_23_45, -1, 2); // R7 four dummies
        frame(1'b1, 8'hD7, 24'h0, -1, 3);        // R8
        frame(1'b0, 8'h57, 24'h0, -1, 1);        // R8
        frame(1'b1, 8'hFF, 24'h12_34_56, -1, 0); // R9
        frame(1'b0, 8'h00, 24'h00_00_00, -1, 0); // R9
        frame(1'b1, 8'h83, 24'h00_12_34, 20, 0); // R10 cut in address
        frame(1'b0, 8'h52, 24'h00_12_34, 40, 0); // R10 cut in dummies
        frame(1'b1, 8'hD6, 24'h00_12_34, 5, 0);  // R10 cut in opcode

        for (int k = 0; k < 40; k++) begin
            logic [7:0]  op = ops[$urandom_range(0, 25)];
            logic [23:0] a  = 24'($urandom);
            bit          m  = 1'($urandom_range(0, 1));
            int          sel = $urandom_range(0, 9);
            if (sel == 0) begin
                op = 8'($urandom);
                if (cls_of(op) != 0) op = 8'hFF;
                frame(m, op, a, -1, 0);
            end else if (sel == 1) begin
                int hdr = (cls_of(op) == 1) ? 1 : 4 + dummies(op);
                frame(m, op, a, $urandom_range(1, hdr * 8 - 1), 0);
            end else begin
                frame(m, op, a, -1, is_read(op) ? 2 : 0);
            end
        end

        done = 1;
        report();
    end
endmodule